// File: doc/BRIEF.md
# Clock-Recovery Lock Source Arbiter

This block chooses which reference a receive clock-recovery loop follows. It can select the incoming serial data, or it can fall back to a local training clock. It also drives an active-low link fault flag.

The block runs on the bit-rate sampling clock. It takes one received bit per `bit_valid` strobe. There is no back-pressure: the block accepts every strobed bit in the cycle it is presented, so no ready signal exists and the sender never stalls. Two flags from outside logic qualify the decision: a signal-level-good flag and a frequency-range-good flag. A built-in run-length monitor adds a third qualifier, transition density. It declares the stream unusable once 60 received bits in a row carry no transition.

A detector-enable control selects which qualifiers count. When it is high, all three qualifiers count. When it is low, only the range flag counts. A use-data control, when low, overrides everything: the block forces reference tracking and reports a fault. Both controls pass through a two-flop synchronizer before use. The block recomputes the selection only on strobe cycles and holds it in a register, so the downstream clock-source multiplexer never sees a glitch.

Top module: `cdr_lock_arb`

## Requirements
- R1: While `rst_n` is low, `track_data` is 0 and `link_fault_n` is 0.
- R2: With detector-enable high, `track_data` becomes 1 only if `level_ok`, `range_ok` and transition density are all good. If `level_ok` is low on a strobe, the block selects the reference (0).
- R3: Transition density fails on the strobe of the 60th consecutive identical bit. With 59 identical bits in a row, it is still good.
- R4: Once density has failed, or after reset before any transition, it stays failed until a strobed bit differs from the bit before it. It becomes good on that strobe.
- R5: With detector-enable low, `track_data` equals `range_ok` as sampled on the strobe. A low `level_ok` and missing transitions have no effect in this mode.
- R6: With `use_data` low, `track_data` is 0 and `link_fault_n` is 0 after every strobe, whatever the qualifiers say.
- R7: Both outputs change only on the clock edge that samples `bit_valid` high. Qualifier changes without a strobe have no effect.
- R8: `link_fault_n` is 1 exactly when `track_data` is 1.
- R9: Outputs reflect the bit and flags of a strobe in the cycle after that strobe's edge. `det_en` and `use_data` are applied once they have been stable for two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Strobe: `bit_data` holds a received bit |
| bit_data | input | 1 | Received bit sample |
| level_ok | input | 1 | Signal level within limits |
| range_ok | input | 1 | Recovered frequency within range of the reference |
| det_en | input | 1 | 1: all three qualifiers count; 0: range only (synchronized) |
| use_data | input | 1 | 0 forces reference tracking and fault (synchronized) |
| track_data | output | 1 | 1: loop follows data; 0: loop follows training reference |
| link_fault_n | output | 1 | Link fault, active low |

## Verification
The hardest condition to reach is the exact density boundary. It takes a run of precisely 59 identical bits, with no trip, followed by a 60th bit that trips. That run must start right after a transition, so the count is known. The stimulus first lays down alternating bits to clear the monitor. It then streams identical bits one strobe at a time, and the scoreboard checks every strobe of the run. A later phase streams 70 identical bits with detection disabled. Re-enabling detection then shows that the hidden density fault was kept and clears only on the next transition.

// File: rtl/cdr_lock_arb_pkg.sv
package cdr_lock_arb_pkg;

  // Clock source chosen for the recovery loop
  typedef enum logic {
    SEL_REF  = 1'b0,
    SEL_DATA = 1'b1
  } lock_sel_e;

  // Qualifier bundle evaluated on each strobe
  typedef struct packed {
    logic level;
    logic range;
    logic dens;
  } qual_t;

  function automatic int unsigned run_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cdr_ctrl_sync.sv
module cdr_ctrl_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cdr_density_mon.sv
module cdr_density_mon
  import cdr_lock_arb_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 60,
  localparam int unsigned RUN_W    = run_width(RUN_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             ok_nxt,
  output logic [RUN_W-1:0] run_len
);

  localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(RUN_LIMIT);
  localparam logic [RUN_W-1:0] ONE_V   = RUN_W'(1);

  logic             have_prev_q;
  logic             prev_bit_q;
  logic [RUN_W-1:0] run_q;
  logic             ok_q;
  logic             edge_seen;
  logic [RUN_W-1:0] run_d;
  logic             ok_d;

  assign edge_seen = have_prev_q && (bit_data != prev_bit_q);

  always_comb begin
    run_d = run_q;
    if (bit_valid) begin
      if (!have_prev_q || edge_seen) run_d = ONE_V;
      else if (run_q < LIMIT_V)      run_d = run_q + ONE_V;
    end
  end

  always_comb begin
    ok_d = ok_q;
    if (bit_valid) begin
      if (edge_seen)             ok_d = 1'b1;
      else if (run_d >= LIMIT_V) ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_bit_q  <= 1'b0;
      run_q       <= '0;
      ok_q        <= 1'b0;
    end else if (bit_valid) begin
      have_prev_q <= 1'b1;
      prev_bit_q  <= bit_data;
      run_q       <= run_d;
      ok_q        <= ok_d;
    end
  end

  assign ok_nxt  = ok_d;
  assign run_len = run_q;

endmodule

// File: rtl/cdr_lock_decide.sv
module cdr_lock_decide
  import cdr_lock_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  qual_t     qual,
  input  logic      det_en_s,
  input  logic      use_data_s,
  output lock_sel_e sel
);

  lock_sel_e sel_q;
  logic      want_data;

  always_comb begin
    want_data = use_data_s && qual.range;
    if (det_en_s) want_data = want_data && qual.level && qual.dens;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_REF;
    else if (strobe) sel_q <= want_data ? SEL_DATA : SEL_REF;
  end

  assign sel = sel_q;

endmodule

// File: rtl/cdr_lock_arb.sv
module cdr_lock_arb
  import cdr_lock_arb_pkg::*;
#(
  parameter int unsigned RUN_LIMIT   = 60,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RUN_W      = run_width(RUN_LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic level_ok,
  input  logic range_ok,
  input  logic det_en,
  input  logic use_data,
  output logic track_data,
  output logic link_fault_n
);

  logic [1:0]       ctl_s;
  logic             det_en_s;
  logic             use_data_s;
  logic             dens_ok;
  logic [RUN_W-1:0] run_len;
  qual_t            qual;
  lock_sel_e        sel;

  cdr_ctrl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({use_data, det_en}),
    .dout (ctl_s)
  );

  assign det_en_s   = ctl_s[0];
  assign use_data_s = ctl_s[1];

  cdr_density_mon #(.RUN_LIMIT(RUN_LIMIT)) u_dens (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .ok_nxt   (dens_ok),
    .run_len  (run_len)
  );

  assign qual.level = level_ok;
  assign qual.range = range_ok;
  assign qual.dens  = dens_ok;

  cdr_lock_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (bit_valid),
    .qual      (qual),
    .det_en_s  (det_en_s),
    .use_data_s(use_data_s),
    .sel       (sel)
  );

  assign track_data   = (sel == SEL_DATA);
  assign link_fault_n = (sel == SEL_DATA);

endmodule

// File: rtl/cdr_lock_arb_chk.sv
module cdr_lock_arb_chk #(
  parameter int unsigned RUN_LIMIT = 60,
  parameter int unsigned RUN_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             level_ok,
  input logic             range_ok,
  input logic             det_en_s,
  input logic             use_data_s,
  input logic [RUN_W-1:0] run_len,
  input logic             track_data,
  input logic             link_fault_n
);

  // R1: reset forces reference tracking and fault
  a_r1_reset_ref: assert property (@(posedge clk)
    !rst_n |-> (!track_data && !link_fault_n));

  // R7: no strobe, no output change
  a_r7_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(track_data) && $stable(link_fault_n)));

  // R6: override forces the reference
  a_r6_force_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !use_data_s) |=> (!track_data && !link_fault_n));

  // R5: range failure always selects the reference
  a_r5_range_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !range_ok) |=> !track_data);

  // R2: low level with detection on selects the reference
  a_r2_level_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && det_en_s && !level_ok) |=> !track_data);

  // R3: run counter saturates at the limit
  a_r3_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_W'(RUN_LIMIT));

endmodule

bind cdr_lock_arb cdr_lock_arb_chk #(.RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_valid   (bit_valid),
  .level_ok    (level_ok),
  .range_ok    (range_ok),
  .det_en_s    (det_en_s),
  .use_data_s  (use_data_s),
  .run_len     (run_len),
  .track_data  (track_data),
  .link_fault_n(link_fault_n)
);

// File: tb/tb_cdr_lock_arb.sv
module tb_cdr_lock_arb;

  localparam int RUN_LIMIT = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic level_ok = 1'b0, range_ok = 1'b0;
  logic det_en = 1'b0, use_data = 1'b0;
  logic track_data, link_fault_n;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  // reference model state (from requirements)
  logic m_have = 1'b0, m_prev = 1'b0, m_dens = 1'b0, m_out = 1'b0;
  int   m_run = 0;
  logic m_det = 1'b0, m_use = 1'b0;

  always #4 clk = ~clk;

  cdr_lock_arb dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .level_ok(level_ok), .range_ok(range_ok), .det_en(det_en),
    .use_data(use_data), .track_data(track_data), .link_fault_n(link_fault_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare one scoreboard item per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(track_data, it.exp, it.tag);
      check(link_fault_n, it.exp, {it.tag, "/R8"});
    end
  end

  task automatic send_bit(input logic b, input logic lvl, input logic rng, input string tag);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = b; level_ok = lvl; range_ok = rng;
    if (!m_have) begin
      m_have = 1'b1; m_run = 1;
    end else if (b != m_prev) begin
      m_run = 1; m_dens = 1'b1;
    end else begin
      if (m_run < RUN_LIMIT) m_run++;
      if (m_run >= RUN_LIMIT) m_dens = 1'b0;
    end
    m_prev = b;
    m_out = m_use && rng && (!m_det || (lvl && m_dens));
    @(posedge clk);
    sb_q.push_back('{m_out, tag});
  endtask

  // idle cycle with qualifiers scrambled: output must hold (R7)
  task automatic idle(input logic lvl, input logic rng);
    @(negedge clk);
    bit_valid = 1'b0; bit_data = ~bit_data; level_ok = lvl; range_ok = rng;
    @(posedge clk);
    sb_q.push_back('{m_out, "R7"});
  endtask

  task automatic set_ctrl(input logic d, input logic u);
    @(negedge clk);
    bit_valid = 1'b0; det_en = d; use_data = u;
    m_det = d; m_use = u;
    @(posedge clk);
    sb_q.push_back('{m_out, "R9"});
    idle(1'b0, 1'b0);
    idle(1'b1, 1'b1);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(track_data, 1'b0, "R1");
    check(link_fault_n, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    set_ctrl(1'b1, 1'b1);

    // R4: first bit after reset has no transition yet; next one clears it
    send_bit(1'b0, 1'b1, 1'b1, "R4");
    send_bit(1'b1, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 6; i++) send_bit(i[0], 1'b1, 1'b1, "R2");
    // R2: level or range low
    send_bit(1'b0, 1'b0, 1'b1, "R2");
    send_bit(1'b1, 1'b1, 1'b1, "R2");
    send_bit(1'b0, 1'b1, 1'b0, "R2");
    send_bit(1'b1, 1'b1, 1'b1, "R2");
    idle(1'b0, 1'b0);
    idle(1'b0, 1'b1);
    // R3: run of identical bits starting from the last '1' (run=1)
    for (int i = 0; i < RUN_LIMIT - 2; i++) send_bit(1'b1, 1'b1, 1'b1, "R3");
    send_bit(1'b1, 1'b1, 1'b1, "R3");   // 60th identical bit: trips
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1, 1'b1, "R4");
    send_bit(1'b0, 1'b1, 1'b1, "R4");
    send_bit(1'b1, 1'b1, 1'b1, "R4");

    // R5: detection off, only range matters
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 70; i++) send_bit(1'b0, 1'b0, 1'b1, "R5");
    send_bit(1'b0, 1'b0, 1'b0, "R5");
    send_bit(1'b0, 1'b1, 1'b1, "R5");

    // R4: detection back on, the density fault was kept
    set_ctrl(1'b1, 1'b1);
    send_bit(1'b0, 1'b1, 1'b1, "R4");
    send_bit(1'b1, 1'b1, 1'b1, "R4");

    // R6: override
    set_ctrl(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(i[0], 1'b1, 1'b1, "R6");
    set_ctrl(1'b0, 1'b0);
    send_bit(1'b1, 1'b1, 1'b1, "R6");
    set_ctrl(1'b1, 1'b1);
    send_bit(1'b0, 1'b1, 1'b1, "R9");
    idle(1'b0, 1'b0);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(track_data, 1'b0, "R1");
    check(link_fault_n, 1'b0, "R1");
    repeat (3) @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule